// File: doc/BRIEF.md
# Program-Status Polling Responder

This block builds the byte a host sees on a read while the memory runs an internal program or erase cycle. When no such cycle runs, the array byte passes through to the data bus as it is. While a cycle runs, the bus carries the status of that cycle instead of the stored byte. The top data line shows the inverse of the top bit of the byte that was loaded last. Line 6 flips after each completed read, so two reads in a row differ on that line for as long as the cycle lasts. The remaining lines repeat the last-loaded byte.

The host may start polling at any point in the cycle. Either it reads until the top line matches the byte it wrote, or it reads until line 6 holds still. A small state machine follows the busy flag with two named states. `ST_IDLE` passes array data through. `ST_BUSY` sends status. The transition `IDLE->BUSY` (start) clears the toggle flop, and the transition `BUSY->IDLE` (done) goes back to passing data through. Both transitions take effect on the clock edge after the busy flag changes. A completed read is a high-to-low edge on the read strobe. The toggle flop advances once for each such edge, not once per clock.

Top module: `prog_status_responder`

## Requirements
- R1: During and just after reset the machine is in `ST_IDLE`, the toggle flop holds 0, and `rd_data_o` equals `array_data_i`.
- R2: In `ST_IDLE`, all 8 bits of `rd_data_o` equal `array_data_i`, whatever `last_data_i` and `rd_strobe_i` do.
- R3: In `ST_BUSY`, bit 7 of `rd_data_o` is the inverse of bit 7 of `last_data_i`.
- R4: In `ST_BUSY`, bits 5 down to 0 of `rd_data_o` equal bits 5 down to 0 of `last_data_i`.
- R5: The `IDLE->BUSY` transition clears the toggle flop. The first read of every busy period therefore shows 0 on bit 6, even when an earlier period left it at 1.
- R6: In `ST_BUSY`, every high-to-low edge of `rd_strobe_i` inverts bit 6 on the following clock edge. A strobe held high for several cycles counts as one read.
- R7: In `ST_BUSY`, bit 6 holds its value across clocks that bring no completed read.
- R8: The state register moves to `ST_BUSY` on the clock edge after `busy_i` is sampled high. It moves to `ST_IDLE` on the clock edge after `busy_i` is sampled low. From that edge on, `rd_data_o` shows true array data and bit 6 no longer toggles.
- R9: Read strobes in `ST_IDLE` do not advance the toggle flop. Bit 6 reads 0 on the first busy read after such strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | High while an internal program or erase cycle runs |
| last_data_i | input | 8 | Byte loaded last by the host |
| array_data_i | input | 8 | Byte read from the array at the current address |
| rd_strobe_i | input | 1 | Read access strobe, high during a read |
| rd_data_o | output | 8 | Data returned to the host |

## Verification
The bench polls across two busy periods, the first ending with bit 6 at 1. A design that skipped the clear at start would then show 1 on the first read of the second period. A read strobe held high for three cycles finds any design that counts clocks instead of edges, because bit 6 would flip more than once. Strobes while idle, and idle clocks during busy, find a toggle flop that advances with no read or outside busy. The reads just after busy falls find a status mux that lingers, or a bus that keeps any inverted or toggling bit.

// File: rtl/psr_pkg.sv
package psr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } psr_state_e;
endpackage

// File: rtl/psr_busy_fsm.sv
module psr_busy_fsm
    import psr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_i,
    output psr_state_e state_o,
    output logic       start_o
);
    psr_state_e state_q;
    psr_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: IDLE->BUSY (start), BUSY->IDLE (done)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (busy_i)  state_d = ST_BUSY;
            ST_BUSY: if (!busy_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_o = 1'b0;
        unique case (state_q)
            ST_IDLE: start_o = busy_i;
            ST_BUSY: start_o = 1'b0;
            default: start_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // R8: state follows the busy flag one edge later
    p_enter_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (state_q == ST_BUSY));
    p_leave_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/psr_toggle.sv
module psr_toggle
    import psr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  psr_state_e state_i,
    input  logic       start_i,
    input  logic       rd_strobe_i,
    output logic       tog_o
);
    logic strobe_q;
    logic read_done;
    logic tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= rd_strobe_i;
    end

    assign read_done = strobe_q & ~rd_strobe_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  tog_q <= 1'b0;
        else if (start_i)                            tog_q <= 1'b0;
        else if (state_i == ST_BUSY && read_done)    tog_q <= ~tog_q;
    end

    assign tog_o = tog_q;

    // R5: start of each busy period clears the flop
    p_clear_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tog_q == 1'b0));
    // R6: one flip per completed read while busy
    p_step_per_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_BUSY && read_done && !start_i) |=> (tog_q != $past(tog_q)));
    // R7 / R9: nothing moves without a completed busy read
    p_hold_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!read_done && !start_i) |=> $stable(tog_q));
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE && !start_i) |=> $stable(tog_q));
endmodule

// File: rtl/psr_data_mux.sv
module psr_data_mux
    import psr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  psr_state_e         state_i,
    input  logic               tog_i,
    input  logic [DATA_W-1:0]  last_i,
    input  logic [DATA_W-1:0]  array_i,
    output logic [DATA_W-1:0]  data_o
);
    logic [DATA_W-1:0] status_w;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign status_w[i] = ~last_i[i];
        end else if (i == TOG_BIT) begin : g_tog
            assign status_w[i] = tog_i;
        end else begin : g_copy
            assign status_w[i] = last_i[i];
        end
    end

    always_comb begin
        data_o = array_i;
        unique case (state_i)
            ST_IDLE: data_o = array_i;
            ST_BUSY: data_o = status_w;
            default: data_o = array_i;
        endcase
    end
endmodule

// File: rtl/prog_status_responder.sv
module prog_status_responder
    import psr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = DATA_W - 1,
    parameter int TOG_BIT  = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] last_data_i,
    input  logic [DATA_W-1:0] array_data_i,
    input  logic              rd_strobe_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int LOW_W = TOG_BIT;

    psr_state_e state_w;
    logic       start_w;
    logic       tog_w;

    psr_busy_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy_i),
        .state_o (state_w),
        .start_o (start_w)
    );

    psr_toggle u_tog (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state_w),
        .start_i     (start_w),
        .rd_strobe_i (rd_strobe_i),
        .tog_o       (tog_w)
    );

    psr_data_mux #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_mux (
        .state_i (state_w),
        .tog_i   (tog_w),
        .last_i  (last_data_i),
        .array_i (array_data_i),
        .data_o  (rd_data_o)
    );

    // R2: idle passes array data untouched
    p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_IDLE) |-> (rd_data_o == array_data_i));
    // R3: busy reports inverted top bit
    p_poll_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_BUSY) |-> (rd_data_o[POLL_BIT] != last_data_i[POLL_BIT]));
    // R4: busy copies the low bits of the last byte
    p_low_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_BUSY) |-> (rd_data_o[LOW_W-1:0] == last_data_i[LOW_W-1:0]));
endmodule

// File: tb/prog_status_responder_test.sv
module prog_status_responder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_i = 1'b0;
    logic [7:0] last_data_i = 8'h00;
    logic [7:0] array_data_i = 8'h00;
    logic       rd_strobe_i = 1'b0;
    logic [7:0] rd_data_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    prog_status_responder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .last_data_i  (last_data_i),
        .array_data_i (array_data_i),
        .rd_strobe_i  (rd_strobe_i),
        .rd_data_o    (rd_data_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status(input logic [7:0] last, input logic tog);
        return {~last[7], tog, last[5:0]};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one read: strobe high for 'hold' cycles; returns the value seen during it
    task automatic do_read(input int hold, output logic [7:0] seen);
        rd_strobe_i = 1'b1;
        step(1);
        seen = rd_data_o;
        if (hold > 1) step(hold - 1);
        rd_strobe_i = 1'b0;
        step(1);
    endtask

    task automatic t_reset;
        array_data_i = 8'h5A;
        step(1);
        check("R1 output during reset", rd_data_o, 8'h5A);
        rst_n = 1'b1;
        step(1);
        check("R1 output after reset", rd_data_o, 8'h5A);
    endtask

    task automatic t_idle_pass;
        logic [7:0] v;
        last_data_i  = 8'hFF;
        array_data_i = 8'h3C;
        do_read(1, v);
        check("R2 idle pass 3C", v, 8'h3C);
        array_data_i = 8'hC3;
        step(1);
        check("R2 idle pass C3", rd_data_o, 8'hC3);
    endtask

    task automatic t_idle_strobes;
        logic [7:0] v;
        do_read(1, v);
        do_read(2, v);
        do_read(1, v);
        check("R9 idle read still passes", v, 8'hC3);
    endtask

    task automatic t_busy_poll;
        logic [7:0] v;
        last_data_i  = 8'hA5;
        array_data_i = 8'h00;
        busy_i = 1'b1;
        step(1);
        check("R8 busy status one edge later", rd_data_o, status(8'hA5, 1'b0));
        do_read(1, v);
        check("R5/R9 first busy read bit6 zero", v, status(8'hA5, 1'b0));
        check("R3 inverted top bit", {7'd0, v[7]}, {7'd0, ~last_data_i[7]});
        check("R4 low bits copied", {2'b00, v[5:0]}, {2'b00, last_data_i[5:0]});
        do_read(1, v);
        check("R6 second read toggled", v, status(8'hA5, 1'b1));
        step(5);
        check("R7 bit6 held with no read", rd_data_o, status(8'hA5, 1'b0));
        do_read(3, v);
        check("R6 third read", v, status(8'hA5, 1'b0));
        check("R6 long strobe flips once", rd_data_o, status(8'hA5, 1'b1));
        last_data_i = 8'h4E;
        step(1);
        check("R3/R4 new last byte", rd_data_o, status(8'h4E, 1'b1));
    endtask

    task automatic t_end_busy;
        logic [7:0] v;
        array_data_i = 8'h96;
        busy_i = 1'b0;
        step(1);
        check("R8 true data after done", rd_data_o, 8'h96);
        do_read(1, v);
        do_read(1, v);
        check("R8 no toggling after done", v, 8'h96);
    endtask

    task automatic t_restart;
        logic [7:0] v;
        last_data_i = 8'h01;
        busy_i = 1'b1;
        step(1);
        do_read(1, v);
        check("R5 restart clears bit6", v, status(8'h01, 1'b0));
        busy_i = 1'b0;
        step(1);
        check("R2 idle again", rd_data_o, 8'h96);
    endtask

    initial begin
        fork
            begin
                step(2);
                t_reset();
                t_idle_pass();
                t_idle_strobes();
                t_busy_poll();
                t_end_busy();
                t_restart();
            end
            begin
                step(5000);
                checks++;
                failures++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule